// File: doc/BRIEF.md
# Two-Wire Block-Protocol Configuration Slave

This block is a slave-only configuration port for a clock-generator style chip. It keeps six 8-bit control registers and exposes them on `cfg_regs` to the surrounding logic. A host reaches the registers over a standard-mode two-wire bus. The block samples SCL and SDA with a fast system clock, detects start and stop conditions, matches its address and acknowledges. It never drives SDA high: it only pulls the line low through `sda_oe`.

A write uses a block sequence. The address byte 0xD2 is followed by two bytes, a command code and a byte count, which the slave acknowledges and then throws away. The data bytes that follow land in register 0, then 1, and so on upward until a stop. A read begins with the address byte 0xD3. The slave then sends the constant 6, then registers 0 to 5, each byte MSB first. There is no register pointer, so every read starts at register 0.

The controller has seven states. ST_IDLE waits for a start. ST_ADDR shifts in the address byte. ST_ADDR_ACK pulls SDA low for the address acknowledge. ST_RX_BYTE shifts in a command, count or data byte. ST_RX_ACK acknowledges that byte. ST_TX_BYTE drives a byte out. ST_TX_ACK samples the host's acknowledge.

The transitions are as follows:
- A start from any state goes to ST_ADDR. A stop from any state goes to ST_IDLE.
- From ST_ADDR, the eighth SCL fall goes to ST_ADDR_ACK on a match and to ST_IDLE otherwise.
- From ST_ADDR_ACK, the next SCL fall goes to ST_TX_BYTE for a read or to ST_RX_BYTE for a write.
- ST_RX_BYTE and ST_RX_ACK alternate on SCL falls.
- From ST_TX_BYTE, the eighth SCL fall goes to ST_TX_ACK.
- From ST_TX_ACK, a high SDA at the SCL rise (a NACK) goes to ST_IDLE. An SCL fall without a NACK goes back to ST_TX_BYTE.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The address byte 0xD2 (write) and 0xD3 (read) is acknowledged with SDA low in the ninth clock. Any other address byte is left unacknowledged, and the slave returns to idle.
- R2: In a write, the first two bytes after the address are acknowledged and change no register.
- R3: In a write, the third and later bytes after the address go to register 0, 1, 2 … in ascending order. Each one is acknowledged. Bits are taken MSB first on the SCL rising edge.
- R4: A stop after any complete byte ends the write. Registers already written keep their new values, and the others stay unchanged.
- R5: Write data bytes beyond register 5 are acknowledged and dropped.
- R6: A read returns the byte count 6, then registers 0 to 5 in order, MSB first.
- R7: In a read, a host NACK ends the transfer and SDA is released. Bytes requested after register 5 read as 0xFF.
- R8: A repeated start at any point restarts the sequence at the address byte and clears the byte-phase counter.
- R9: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xFF.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: A stop returns the slave to idle. Bytes clocked afterwards without a new start are neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, loads the register defaults |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low; otherwise SDA is released |
| cfg_regs | output | 48 | Register contents, register k in bits 8k+7:8k |

## Verification
The checker watches four things on every cycle:
- the SDA drive changes only while the synchronised SCL is low;
- a start always lands in the address state, and a stop always lands in idle;
- a register changes only in the cycle after a receive byte completes;
- a host NACK during a read releases SDA and idles the controller.

Only the bench's bus scenarios can show the protocol-level results. These are which address values are acknowledged, that the command and count bytes are discarded, and that data lands in the right register for every stop position. They also cover the read-back order and count, the 0xFF fill past the last register, the recovery after a repeated start in mid-write, and that nothing happens after a stop without a new start.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX_BYTE,
        ST_RX_ACK,
        ST_TX_BYTE,
        ST_TX_ACK
    } cfg_state_t;

endpackage

// File: rtl/cfgi2c_sync.sv
// Brings SCL and SDA into the clk domain and flags edges and bus conditions.
module cfgi2c_sync #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_N-1:0] scl_pipe;
    logic [SYNC_N-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_N-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_N-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_N-1];
            sda_q    <= sda_pipe[SYNC_N-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_N-1];
    assign sda_s     = sda_pipe[SYNC_N-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA moving while SCL stays high marks a bus condition.
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfgi2c_regfile.sv
// Control register bank with per-register reset defaults.
module cfgi2c_regfile #(
    parameter int unsigned          NREG         = 6,
    parameter logic [NREG*8-1:0]    REG_DEFAULTS = '0,
    localparam int unsigned         IDX_W        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_data,
    output logic [NREG*8-1:0]    regs_flat
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [7:0] value;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                value <= REG_DEFAULTS[g*8 +: 8];
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                value <= wr_data;
            end
        end

        assign regs_flat[g*8 +: 8] = value;
    end

endmodule

// File: rtl/cfgi2c_fsm.sv
// Protocol controller: address match, block write/read phases, ACK drive.
module cfgi2c_fsm
    import cfgi2c_pkg::*;
#(
    parameter int unsigned  NREG     = 6,
    parameter logic [6:0]   DEV_ADDR = 7'h69,
    localparam int unsigned IDX_W    = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int unsigned PH_MAX   = NREG + 2,
    localparam int unsigned PH_W     = $clog2(PH_MAX + 1),
    localparam int unsigned RD_W     = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [NREG*8-1:0] regs_flat,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [7:0]        wr_data,
    output logic              sda_oe,
    output cfg_state_t        st_o
);

    cfg_state_t        st;
    cfg_state_t        st_nx;
    logic [3:0]        bit_cnt;
    logic [7:0]        shift;
    logic              is_read;
    logic [PH_W-1:0]   byte_ph;
    logic [7:0]        tx_sh;
    logic [RD_W-1:0]   rd_idx;
    logic [7:0]        next_tx;
    logic              byte_done;
    logic              addr_hit;

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign addr_hit  = (shift[7:1] == DEV_ADDR);

    always_comb begin
        if (rd_idx < RD_W'(NREG)) begin
            next_tx = regs_flat[int'(rd_idx)*BYTE_W +: BYTE_W];
        end else begin
            next_tx = 8'hFF;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        if (start_det) begin
            st_nx = ST_ADDR;
        end else if (stop_det) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:     st_nx = ST_IDLE;
                ST_ADDR:     if (byte_done) st_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) st_nx = is_read ? ST_TX_BYTE : ST_RX_BYTE;
                ST_RX_BYTE:  if (byte_done) st_nx = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) st_nx = ST_RX_BYTE;
                ST_TX_BYTE:  if (scl_fall && (bit_cnt == 4'd7)) st_nx = ST_TX_ACK;
                ST_TX_ACK: begin
                    if (scl_rise && sda_s) begin
                        st_nx = ST_IDLE;
                    end else if (scl_fall) begin
                        st_nx = ST_TX_BYTE;
                    end
                end
                default:     st_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath: bit counter, shifters, byte phase and read index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shift   <= '0;
            is_read <= 1'b0;
            byte_ph <= '0;
            tx_sh   <= '1;
            rd_idx  <= '0;
        end else if (start_det) begin
            bit_cnt <= '0;
            byte_ph <= '0;
            is_read <= 1'b0;
            tx_sh   <= '1;
        end else begin
            case (st)
                ST_ADDR, ST_RX_BYTE: begin
                    if (scl_rise) begin
                        shift   <= {shift[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done && (st == ST_ADDR)) begin
                        is_read <= shift[0];
                    end
                    if (byte_done && (st == ST_RX_BYTE) && (byte_ph != PH_W'(PH_MAX))) begin
                        byte_ph <= byte_ph + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (is_read) begin
                            tx_sh  <= BYTE_W'(NREG);
                            rd_idx <= '0;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                    end
                end
                ST_TX_BYTE: begin
                    if (scl_fall && (bit_cnt != 4'd7)) begin
                        tx_sh   <= {tx_sh[6:0], 1'b1};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_fall) begin
                        tx_sh   <= next_tx;
                        bit_cnt <= '0;
                        if (rd_idx != RD_W'(NREG)) begin
                            rd_idx <= rd_idx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (st)
            ST_ADDR_ACK, ST_RX_ACK: sda_oe = 1'b1;
            ST_TX_BYTE:             sda_oe = ~tx_sh[7];
            default:                sda_oe = 1'b0;
        endcase
        wr_en   = (st == ST_RX_BYTE) && byte_done &&
                  (byte_ph >= PH_W'(2)) && (byte_ph < PH_W'(PH_MAX));
        wr_idx  = IDX_W'(byte_ph - PH_W'(2));
        wr_data = shift;
        st_o    = st;
    end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfgi2c_pkg::*;
#(
    parameter int unsigned        NREG         = 6,
    parameter logic [6:0]         DEV_ADDR     = 7'h69,
    parameter logic [NREG*8-1:0]  REG_DEFAULTS = {40'hFF_FFFF_FFFF, 8'h00},
    parameter int unsigned        SYNC_N       = 2,
    localparam int unsigned       IDX_W        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_regs
);

    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    cfg_state_t       fsm_st;

    cfgi2c_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgi2c_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .regs_flat (cfg_regs),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe),
        .st_o      (fsm_st)
    );

    cfgi2c_regfile #(.NREG(NREG), .REG_DEFAULTS(REG_DEFAULTS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: rtl/cfgi2c_chk.sv
module cfgi2c_chk
    import cfgi2c_pkg::*;
#(
    parameter int unsigned NREG = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_s,
    input logic              scl_rise,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input cfg_state_t        st,
    input logic [NREG*8-1:0] regs
);

    // R10: drive changes only while synchronised SCL is low
    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R8: a start condition always restarts at the address byte
    assert_start_to_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR));

    // R11: a stop condition always idles the controller
    assert_stop_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (st == ST_IDLE));

    // R4: registers move only right after a received byte
    assert_regs_only_on_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs) |-> ($past(st) == ST_RX_BYTE));

    // R7: host NACK during a read releases SDA and idles
    assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_TX_ACK) && scl_rise && sda_s && !start_det && !stop_det)
            |=> ((st == ST_IDLE) && !sda_oe));

endmodule

bind cfg_i2c_slave cfgi2c_chk #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .st        (fsm_st),
    .regs      (cfg_regs)
);

// File: tb/tb_cfg_i2c_slave.sv
`timescale 1ns/1ps
module tb_cfg_i2c_slave;

    localparam int NREG = 6;
    localparam int Q    = 10;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int r10_viol = 0;
    logic oe_prev = 1'b0;
    bit done = 1'b0;
    logic [7:0] model [NREG];

    always #4 clk = ~clk;

    cfg_i2c_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (regs)
    );

    // R10 monitor: drive must not move while the master holds SCL high
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) r10_viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input bit send_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = send_ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            chk(regs[i*8 +: 8] == model[i], req, regs[i*8 +: 8], model[i]);
    endtask

    // R6: count then registers 0..5, NACK on the last
    task automatic read_all();
        bit ack;
        logic [7:0] b;
        bus_start();
        put_byte(8'hD3, ack);
        chk(ack, "R1", ack, 1);
        get_byte(1'b1, b);
        chk(b == 8'(NREG), "R6", b, NREG);
        for (int i = 0; i < NREG; i++) begin
            get_byte(i != NREG-1, b);
            chk(b == model[i], "R6", b, model[i]);
        end
        bus_stop();
    endtask

    task automatic do_write(input int n, input int seed);
        bit ack;
        logic [7:0] d;
        bus_start();
        put_byte(8'hD2, ack);
        chk(ack, "R1", ack, 1);
        put_byte(8'(seed*11 + 3), ack);
        chk(ack, "R2", ack, 1);
        put_byte(8'(seed*7 + 1), ack);
        chk(ack, "R2", ack, 1);
        for (int i = 0; i < n; i++) begin
            d = 8'(seed*53 + i*97 + 17);
            put_byte(d, ack);
            if (i < NREG) begin
                model[i] = d;
                chk(ack, "R3", ack, 1);
            end else begin
                chk(ack, "R5", ack, 1);
            end
        end
        bus_stop();
        if (n == 0)         check_regs("R2");
        else if (n < NREG)  check_regs("R4");
        else                check_regs("R5");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        logic [7:0] a;

        model[0] = 8'h00;
        for (int i = 1; i < NREG; i++) model[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R9 reset state
        chk(sda_oe == 1'b0, "R9", sda_oe, 0);
        check_regs("R9");
        read_all();

        // R2 R3 R4 R5 sweep of stop position
        for (int n = 0; n <= NREG + 2; n++) begin
            do_write(n, n + 1);
            read_all();
        end

        // R1 address sweep: only D2/D3 acknowledged
        for (int x = 0; x < 256; x += 5) begin
            a = 8'(x);
            if (a != 8'hD2 && a != 8'hD3) begin
                bus_start();
                put_byte(a, ack);
                chk(!ack, "R1", ack, 0);
                bus_stop();
            end
        end
        for (int k = 0; k < 8; k++) begin
            for (int base = 0; base < 2; base++) begin
                a = (base == 0 ? 8'hD2 : 8'hD3) ^ (8'h01 << k);
                if (a != 8'hD2 && a != 8'hD3) begin
                    bus_start();
                    put_byte(a, ack);
                    chk(!ack, "R1", ack, 0);
                    bus_stop();
                end
            end
        end
        check_regs("R1");

        // R7 read past the last register
        bus_start();
        put_byte(8'hD3, ack);
        chk(ack, "R1", ack, 1);
        get_byte(1'b1, b);
        chk(b == 8'(NREG), "R6", b, NREG);
        for (int i = 0; i < NREG + 2; i++) begin
            get_byte(i != NREG + 1, b);
            chk(b == (i < NREG ? model[i] : 8'hFF), "R7", b, (i < NREG ? model[i] : 8'hFF));
        end
        bus_stop();

        // R7 early NACK releases SDA
        bus_start();
        put_byte(8'hD3, ack);
        get_byte(1'b0, b);
        chk(b == 8'(NREG), "R6", b, NREG);
        get_byte(1'b0, b);
        chk(b == 8'hFF, "R7", b, 8'hFF);
        bus_stop();

        // R8 repeated start mid-write restarts the byte phase
        bus_start();
        put_byte(8'hD2, ack);
        put_byte(8'h44, ack);
        put_byte(8'h06, ack);
        bus_start();
        put_byte(8'hD2, ack);
        chk(ack, "R8", ack, 1);
        put_byte(8'h11, ack);
        put_byte(8'h22, ack);
        put_byte(8'h3C, ack);
        model[0] = 8'h3C;
        chk(ack, "R8", ack, 1);
        bus_start();
        put_byte(8'hD3, ack);
        chk(ack, "R8", ack, 1);
        get_byte(1'b1, b);
        chk(b == 8'(NREG), "R8", b, NREG);
        get_byte(1'b0, b);
        chk(b == 8'h3C, "R8", b, 8'h3C);
        bus_stop();
        check_regs("R8");

        // R11 bytes after a stop without a new start are ignored
        bus_start();
        put_byte(8'hD2, ack);
        put_byte(8'h00, ack);
        bus_stop();
        put_byte(8'hD2, ack);
        chk(!ack, "R11", ack, 0);
        put_byte(8'h99, ack);
        chk(!ack, "R11", ack, 0);
        bus_stop();
        check_regs("R11");
        read_all();

        chk(r10_viol == 0, "R10", r10_viol, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule